// File: doc/BRIEF.md
# SPI Serial Memory Slave with Block Protection

This block is an SPI slave that fronts a byte-wide memory array held in flip-flops. It accepts SPI modes 0 and 3. Each transaction starts with an 8-bit command byte. The commands set and clear a write-enable latch, set and clear a software flag, read and write a status register, stream bytes out of the array with an auto-incrementing address, and load up to one page of bytes into the array. All SPI pins are sampled in the system clock domain. The SPI clock must therefore run well below the system clock. The bench uses 12 system clocks per SPI bit.

A write is accepted only under three conditions: the write-enable latch was set beforehand, chip select rises exactly on a byte boundary, and the target is not locked. When a write is accepted, the block runs a self-timed write cycle of a parameterised number of clocks, and the busy bit reads 1 for that time. Address ranges are locked by a two-bit field in the status register. Status writes are locked by a status bit combined with an active-low write-protect pin.

The serial link has no back-pressure. The master owns the SPI clock, so every byte must be accepted or produced at the rate the master sets. The block has no valid/ready edge.

Top module: `spim_slave`

## Requirements
- R1: A status read returns, from bit 7 down to bit 0: protect-enable, flag, two watchdog-select bits, two block-lock bits, write-enable, busy. The status byte repeats for as long as clocking continues.
- R2: MOSI is sampled on SCK rising edges, most significant bit first. MISO changes on SCK falling edges. The MISO output enable is 0 while chip select is high.
- R3: Command 0x06 sets write-enable only when chip select rises after exactly that one byte. Any further bit or byte in the same selection cancels it.
- R4: Command 0x04 clears write-enable and the flag. Command 0x00 sets the flag.
- R5: Command 0x03 takes a 16-bit address, taken modulo the array size. It then streams bytes from successive addresses and wraps from the top address to 0.
- R6: Command 0x02 takes a 16-bit address and data bytes. The address wraps inside its 32-byte page, so later bytes overwrite earlier ones in that page.
- R7: A write or status write commits only if write-enable is 1, at least one data byte was received, and chip select rises on a byte boundary. Otherwise nothing changes.
- R8: The block-lock field 00 locks nothing. 01 locks 0x600–0x7FF. 10 locks 0x400–0x7FF. 11 locks the whole array. Writes to locked bytes are dropped, and locked bytes stay readable.
- R9: A status write (command 0x01) is refused when protect-enable is 1 and the write-protect pin is low. The data byte's bits 1:0 never change status bits 1:0.
- R10: After a commit, busy reads 1 for the write-cycle length. Write-enable is 0 when busy drops. The status register stays readable throughout.
- R11: While busy, every command other than the status read (0x05) is ignored.
- R12: After reset, the status register is 0x00, every array byte is 0xFF, and MISO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_en | output | 1 | Output enable for spi_miso |
| wp_n | input | 1 | Write-protect pin, active low |

## Verification
The bench builds the block with an 11-bit address, so the full 2048-byte array is present. This makes the quarter and half lock boundaries at 0x600 and 0x400 reachable, along with the top-address read wrap. It uses 32-byte pages. The write cycle is 600 clocks: short enough for many writes per run, but long enough that a status poll and an ignored command both fit inside one busy window. Both SPI modes are used for stores and readbacks. Directed sequences cover cancelled enables, writes aborted mid-byte, every lock setting, and the pin-plus-bit status lock.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] CMD_FLAG_SET = 8'h00;
  localparam logic [7:0] CMD_SR_WRITE = 8'h01;
  localparam logic [7:0] CMD_WRITE    = 8'h02;
  localparam logic [7:0] CMD_READ     = 8'h03;
  localparam logic [7:0] CMD_WE_CLR   = 8'h04;
  localparam logic [7:0] CMD_SR_READ  = 8'h05;
  localparam logic [7:0] CMD_WE_SET   = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_STREAM_OUT,
    PH_LOAD_PAGE,
    PH_SR_DATA,
    PH_SR_OUT,
    PH_DISCARD
  } phase_e;
endpackage

// File: rtl/spim_link.sv
module spim_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       csn,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       miso,
  output logic       miso_en,
  output logic       sel_fall,
  output logic       sel_rise,
  output logic       at_boundary,
  output logic       byte_vld,
  output logic [7:0] rx_byte,
  output logic       tx_load
);
  logic [1:0] sck_m, csn_m, mosi_m;
  logic       sck_d, csn_d;
  logic       sck_s, csn_s, mosi_s;
  logic       edge_up, edge_dn;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  assign sck_s  = sck_m[1];
  assign csn_s  = csn_m[1];
  assign mosi_s = mosi_m[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= 2'b00;
      csn_m  <= 2'b11;
      mosi_m <= 2'b00;
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sck_m  <= {sck_m[0], sck};
      csn_m  <= {csn_m[0], csn};
      mosi_m <= {mosi_m[0], mosi};
      sck_d  <= sck_s;
      csn_d  <= csn_s;
    end
  end

  assign edge_up     = sck_s & ~sck_d & ~csn_s;
  assign edge_dn     = ~sck_s & sck_d & ~csn_s;
  assign sel_fall    = csn_d & ~csn_s;
  assign sel_rise    = ~csn_d & csn_s;
  assign at_boundary = (bit_cnt == 3'd0);
  assign tx_load     = edge_dn & at_boundary;
  assign miso        = tx_sr[7];
  assign miso_en     = ~csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= 3'd0;
      rx_sr    <= 7'd0;
      rx_byte  <= 8'd0;
      byte_vld <= 1'b0;
      tx_sr    <= 8'd0;
    end else if (csn_s) begin
      bit_cnt  <= 3'd0;
      rx_sr    <= 7'd0;
      byte_vld <= 1'b0;
      tx_sr    <= 8'd0;
    end else begin
      byte_vld <= 1'b0;
      if (edge_up) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          rx_byte  <= {rx_sr, mosi_s};
        end
      end
      if (edge_dn) begin
        if (at_boundary) tx_sr <= tx_next;
        else             tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  // R2: the output shifter moves only on a selected falling SCK edge
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_dn && !csn_s) |=> $stable(tx_sr));

  // R2: a byte completes only on a rising SCK edge
  p_byte_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_vld) |-> $past(edge_up));
endmodule

// File: rtl/spim_guard.sv
module spim_guard (
  input  logic [1:0] lock_field,
  input  logic [1:0] page_top,
  output logic       locked
);
  always_comb begin
    unique case (lock_field)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &page_top;
      2'b10:   locked = page_top[1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/spim_store.sv
module spim_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spim_slave.sv
module spim_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  parameter int WCYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_en,
  input  logic wp_n
);
  import spim_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PN_W       = ADDR_W - PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int CW         = $clog2(WCYC + 1);

  initial begin
    assert (WCYC > PAGE_BYTES);
    assert (ADDR_W > 9 && ADDR_W <= 16);
    assert (PN_W >= 2);
  end

  // link interface
  logic       sel_fall, sel_rise, at_boundary, byte_vld, tx_load;
  logic [7:0] rx_byte, tx_next;

  // status bits
  logic       prot_en, flag, wel, busy;
  logic [1:0] wd_sel, lock_field;
  logic [7:0] status_w;

  // command state
  phase_e            phase;
  logic              is_write, wren_arm, data_seen, cyc_sr;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] rd_addr, addr_full;
  logic [PN_W-1:0]   page_num;
  logic [PAGE_W-1:0] page_off;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [5:0]        sr_data;
  logic [CW-1:0]     cyc_cnt;

  // array ports
  logic              arr_we;
  logic [PAGE_W-1:0] drain_idx;
  logic [7:0]        rd_data;
  logic              page_locked, sr_locked;

  assign status_w  = {prot_en, flag, wd_sel, lock_field, wel, busy};
  assign addr_full = {addr_hi, rx_byte};
  assign sr_locked = prot_en & ~wp_n;
  assign drain_idx = cyc_cnt[PAGE_W-1:0];
  assign arr_we    = busy & ~cyc_sr & (cyc_cnt < CW'(PAGE_BYTES)) & pmask[drain_idx];

  always_comb begin
    unique case (phase)
      PH_SR_OUT:     tx_next = status_w;
      PH_STREAM_OUT: tx_next = rd_data;
      default:       tx_next = 8'h00;
    endcase
  end

  spim_link u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (spi_sck),
    .csn        (spi_csn),
    .mosi       (spi_mosi),
    .tx_next    (tx_next),
    .miso       (spi_miso),
    .miso_en    (spi_miso_en),
    .sel_fall   (sel_fall),
    .sel_rise   (sel_rise),
    .at_boundary(at_boundary),
    .byte_vld   (byte_vld),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load)
  );

  spim_guard u_guard (
    .lock_field(lock_field),
    .page_top  (page_num[PN_W-1 -: 2]),
    .locked    (page_locked)
  );

  spim_store #(.ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (arr_we),
    .waddr({page_num, drain_idx}),
    .wdata(pbuf[drain_idx]),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (byte_vld && phase == PH_LOAD_PAGE) pbuf[page_off] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_en    <= 1'b0;
      flag       <= 1'b0;
      wd_sel     <= 2'b00;
      lock_field <= 2'b00;
      wel        <= 1'b0;
      busy       <= 1'b0;
      phase      <= PH_CMD;
      is_write   <= 1'b0;
      wren_arm   <= 1'b0;
      data_seen  <= 1'b0;
      cyc_sr     <= 1'b0;
      addr_hi    <= '0;
      rd_addr    <= '0;
      page_num   <= '0;
      page_off   <= '0;
      pmask      <= '0;
      sr_data    <= '0;
      cyc_cnt    <= '0;
    end else begin
      // self-timed write cycle
      if (busy) begin
        cyc_cnt <= cyc_cnt + CW'(1);
        if (cyc_cnt == CW'(WCYC - 1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (cyc_sr) {prot_en, flag, wd_sel, lock_field} <= sr_data;
        end
      end

      // byte-level command decode
      if (sel_fall) begin
        phase     <= PH_CMD;
        wren_arm  <= 1'b0;
        data_seen <= 1'b0;
      end else if (byte_vld) begin
        unique case (phase)
          PH_CMD: begin
            if (busy && rx_byte != CMD_SR_READ) begin
              phase <= PH_DISCARD;
            end else begin
              unique case (rx_byte)
                CMD_WE_SET: begin
                  wren_arm <= 1'b1;
                  phase    <= PH_DISCARD;
                end
                CMD_WE_CLR: begin
                  wel   <= 1'b0;
                  flag  <= 1'b0;
                  phase <= PH_DISCARD;
                end
                CMD_FLAG_SET: begin
                  flag  <= 1'b1;
                  phase <= PH_DISCARD;
                end
                CMD_SR_READ:  phase <= PH_SR_OUT;
                CMD_SR_WRITE: phase <= PH_SR_DATA;
                CMD_READ: begin
                  is_write <= 1'b0;
                  phase    <= PH_ADDR_HI;
                end
                CMD_WRITE: begin
                  is_write <= 1'b1;
                  pmask    <= '0;
                  phase    <= PH_ADDR_HI;
                end
                default: phase <= PH_DISCARD;
              endcase
            end
          end
          PH_ADDR_HI: begin
            addr_hi <= rx_byte[HI_W-1:0];
            phase   <= PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            if (is_write) begin
              page_num <= addr_full[ADDR_W-1:PAGE_W];
              page_off <= addr_full[PAGE_W-1:0];
              phase    <= PH_LOAD_PAGE;
            end else begin
              rd_addr <= addr_full;
              phase   <= PH_STREAM_OUT;
            end
          end
          PH_LOAD_PAGE: begin
            pmask[page_off] <= 1'b1;
            page_off        <= page_off + PAGE_W'(1);
            data_seen       <= 1'b1;
          end
          PH_SR_DATA: begin
            sr_data   <= rx_byte[7:2];
            data_seen <= 1'b1;
          end
          PH_DISCARD: wren_arm <= 1'b0;
          default: ;
        endcase
      end

      if (tx_load && phase == PH_STREAM_OUT) rd_addr <= rd_addr + ADDR_W'(1);

      // end of selection: commit decisions
      if (sel_rise && at_boundary) begin
        if (wren_arm) wel <= 1'b1;
        if (phase == PH_LOAD_PAGE && data_seen && wel && !page_locked && !busy) begin
          busy    <= 1'b1;
          cyc_sr  <= 1'b0;
          cyc_cnt <= '0;
        end
        if (phase == PH_SR_DATA && data_seen && wel && !sr_locked && !busy) begin
          busy    <= 1'b1;
          cyc_sr  <= 1'b1;
          cyc_cnt <= '0;
        end
      end
    end
  end

  // R10: busy lasts exactly the configured cycle length
  p_wip_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cyc_cnt) == CW'(WCYC - 1)));

  // R10: write-enable is down when the cycle ends
  p_wel_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R8: no array store lands in a locked range
  p_locked_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !page_locked);

  // R11: a non-status command arriving while busy is dropped
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && byte_vld && !sel_fall && busy && rx_byte != CMD_SR_READ)
      |=> (phase == PH_DISCARD));

  // R9: stored status bits change only at the end of a status write cycle
  p_sr_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({prot_en, wd_sel, lock_field}) |-> ($past(busy) && $past(cyc_sr)));

  // R3: write-enable rises only as a selection ends
  p_wel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(sel_rise));
endmodule

// File: tb/spim_slave_tb.sv
`timescale 1ns/1ps
module spim_slave_tb;
  localparam int ADDR_W = 11;
  localparam int PAGE_W = 5;
  localparam int WCYC   = 600;
  localparam int HALF   = 48;

  // mode bit, address, data
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 16'h0012, 8'h3C},
    {1'b1, 16'hF813, 8'h81},
    {1'b0, 16'h07FF, 8'h5A},
    {1'b1, 16'h0000, 8'hC3},
    {1'b0, 16'h0355, 8'hA5},
    {1'b1, 16'h0180, 8'h0F}
  };

  logic clk = 1'b0;
  logic rst_n, sck, csn, mosi, wp_n;
  logic miso, miso_en;
  logic mode3 = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  spim_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WCYC(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .wp_n(wp_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic sel_on();
    sck = mode3;
    #(HALF);
    csn = 1'b0;
    #(HALF);
  endtask

  task automatic sel_off();
    #(HALF);
    csn = 1'b1;
    #(HALF * 2);
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      if (mode3) sck = 1'b0;
      mosi = b[i];
      #(HALF);
      r[i] = miso;
      sck = 1'b1;
      #(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xfer_bits(b, 8, r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] t;
    sel_on(); xfer(op, t); sel_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] t;
    sel_on(); xfer(8'h05, t); xfer(8'h00, s); sel_off();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] t;
    sel_on(); xfer(8'h01, t); xfer(v, t); sel_off();
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] t;
    sel_on(); xfer(8'h02, t); xfer(a[15:8], t); xfer(a[7:0], t); xfer(d, t); sel_off();
  endtask

  task automatic rd_byte(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] t;
    sel_on(); xfer(8'h03, t); xfer(a[15:8], t); xfer(a[7:0], t); xfer(8'h00, d); sel_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, d1, t;
    rst_n = 1'b0; csn = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 / R2: reset state
    chk("R2 miso disabled while deselected", {7'd0, miso_en}, 8'h00);
    rdsr(s);
    chk("R12 status after reset", s, 8'h00);
    rd_byte(16'h0100, d);
    chk("R12 erased array byte", d, 8'hFF);
    sel_on();
    chk("R2 miso enabled while selected", {7'd0, miso_en}, 8'h01);
    sel_off();

    // table walk: store then read back, both SPI modes
    for (int k = 0; k < 6; k++) begin
      mode3 = VEC[k][24];
      cmd1(8'h06);
      wr_byte(VEC[k][23:8], VEC[k][7:0]);
      wait_idle();
      rd_byte(VEC[k][23:8] & 16'h07FF, d);
      chk("R5 R7 table store and readback", d, VEC[k][7:0]);
    end
    mode3 = 1'b0;

    // R3: enable cancelled by an extra byte or a partial byte
    sel_on(); xfer(8'h06, t); xfer(8'h00, t); sel_off();
    rdsr(s);
    chk("R3 enable cancelled by extra byte", s, 8'h00);
    sel_on(); xfer(8'h06, t); xfer_bits(8'hFF, 3, t); sel_off();
    rdsr(s);
    chk("R3 enable cancelled by partial byte", s, 8'h00);
    cmd1(8'h06);
    rdsr(s);
    chk("R3 R1 enable set", s, 8'h02);

    // R4: clear enable, flag set/clear
    cmd1(8'h04);
    rdsr(s);
    chk("R4 enable cleared", s, 8'h00);
    cmd1(8'h00);
    rdsr(s);
    chk("R4 R1 flag set", s, 8'h40);
    cmd1(8'h04);
    rdsr(s);
    chk("R4 flag cleared", s, 8'h00);

    // R6 / R10: page wrap and busy window
    cmd1(8'h06);
    sel_on();
    xfer(8'h02, t); xfer(8'h00, t); xfer(8'h3E, t);
    xfer(8'hA0, t); xfer(8'hA1, t); xfer(8'hA2, t); xfer(8'hA3, t);
    sel_off();
    rdsr(s);
    chk("R10 busy and enable during cycle", s, 8'h03);
    wait_idle();
    rdsr(s);
    chk("R10 enable cleared after cycle", s, 8'h00);
    rd_byte(16'h003E, d);
    chk("R6 page byte 0x3E", d, 8'hA0);
    rd_byte(16'h003F, d);
    chk("R6 page byte 0x3F", d, 8'hA1);
    rd_byte(16'h0020, d);
    chk("R6 wrapped byte 0x20", d, 8'hA2);
    rd_byte(16'h0021, d);
    chk("R6 wrapped byte 0x21", d, 8'hA3);
    rd_byte(16'h0040, d);
    chk("R6 next page untouched", d, 8'hFF);

    // R5: stream across the top address
    sel_on();
    xfer(8'h03, t); xfer(8'h07, t); xfer(8'hFF, t); xfer(8'h00, d); xfer(8'h00, d1);
    sel_off();
    chk("R5 stream top byte", d, 8'h5A);
    chk("R5 stream wraps to 0", d1, 8'hC3);

    // R7: aborted and unenabled writes
    cmd1(8'h06);
    sel_on();
    xfer(8'h02, t); xfer(8'h01, t); xfer(8'h00, t); xfer(8'h11, t); xfer_bits(8'hFF, 3, t);
    sel_off();
    rdsr(s);
    chk("R7 aborted write starts no cycle", s, 8'h02);
    rd_byte(16'h0100, d);
    chk("R7 aborted write leaves array", d, 8'hFF);
    cmd1(8'h04);
    wr_byte(16'h0101, 8'h22);
    rdsr(s);
    chk("R7 write without enable no cycle", s, 8'h00);
    rd_byte(16'h0101, d);
    chk("R7 write without enable dropped", d, 8'hFF);

    // R8: lock settings
    cmd1(8'h06); wrsr(8'h04); wait_idle();
    rdsr(s);
    chk("R8 R1 lock quarter in status", s, 8'h04);
    cmd1(8'h06); wr_byte(16'h0600, 8'h33); wait_idle();
    rd_byte(16'h0600, d);
    chk("R8 quarter locked 0x600", d, 8'hFF);
    cmd1(8'h06); wr_byte(16'h05FF, 8'h44); wait_idle();
    rd_byte(16'h05FF, d);
    chk("R8 quarter open 0x5FF", d, 8'h44);
    rd_byte(16'h07FF, d);
    chk("R8 locked bytes readable", d, 8'h5A);
    cmd1(8'h06); wrsr(8'h08); wait_idle();
    cmd1(8'h06); wr_byte(16'h0400, 8'h66); wait_idle();
    rd_byte(16'h0400, d);
    chk("R8 half locked 0x400", d, 8'hFF);
    cmd1(8'h06); wr_byte(16'h03FF, 8'h77); wait_idle();
    rd_byte(16'h03FF, d);
    chk("R8 half open 0x3FF", d, 8'h77);
    cmd1(8'h06); wrsr(8'h0C); wait_idle();
    cmd1(8'h06); wr_byte(16'h0010, 8'h99); wait_idle();
    rd_byte(16'h0010, d);
    chk("R8 full lock 0x010", d, 8'hFF);
    cmd1(8'h04);
    cmd1(8'h06); wrsr(8'h00); wait_idle();

    // R9: low bits ignored, pin-plus-bit lock
    cmd1(8'h06); wrsr(8'h03); wait_idle();
    rdsr(s);
    chk("R9 low status bits unchanged", s, 8'h00);
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h80); wait_idle();
    rdsr(s);
    chk("R9 protect-enable set with pin low", s, 8'h80);
    cmd1(8'h06); wrsr(8'h8C);
    rdsr(s);
    chk("R9 status write refused when locked", s, 8'h82);
    wp_n = 1'b1;
    wrsr(8'h00); wait_idle();
    rdsr(s);
    chk("R9 status write allowed with pin high", s, 8'h00);

    // R11: commands ignored while busy
    cmd1(8'h06);
    wr_byte(16'h0200, 8'h55);
    cmd1(8'h00);
    cmd1(8'h06);
    wait_idle();
    rdsr(s);
    chk("R11 flag and enable untouched by busy commands", s, 8'h00);
    rd_byte(16'h0200, d);
    chk("R11 write in flight completes", d, 8'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule